// File: doc/BRIEF.md
# Colour LCD Controller Register Block

This block is the bus-facing register file of a colour LCD controller. A host reaches it through an APB-style slave port over a 4 KB address window. It stores four panel timing words, the frame base addresses of the upper and lower panels, a control word and an interrupt enable mask. It keeps raw interrupt status, which hardware event strobes set and software clears. It also serves a fixed set of identification bytes.

From the first two timing words it decodes the active panel width and height, and it presents them as plain outputs for the timing and DMA engines. A sub-window of palette words is forwarded without change to a separate palette store. Every write in the window raises a one-cycle invalidate pulse, so the display side knows to refetch its settings.

A parameter selects one of three variants. Variant 0 is the base layout. Variants 1 and 2 swap the addresses of the mask and control words. Variant 2 also reports a different identification set.

Top module: `lcdc_regs`

## Requirements
- R1: After reset every stored register reads zero and `irq_o` is low. `cols_o` reads 16 and `rows_o` reads 1.
- R2: The word at byte offset 4*i holds timing word i for i = 0..3. Offset 0x10 holds the upper base and offset 0x14 holds the lower base. A write at one of these offsets is read back unchanged, and the upper base, lower base and control word are driven on `upbase_o`, `lpbase_o` and `ctrl_o`.
- R3: With VARIANT 0, offset 0x18 is the interrupt mask (NIRQ bits, read zero-extended) and offset 0x1C is the control word. With VARIANT 1 or 2 the two addresses are exchanged, for reads and for writes alike.
- R4: `cols_o` equals ((timing0 AND 0xFC) + 4) * 4. No other bit of timing0 affects it.
- R5: `rows_o` equals (timing1 AND 0x3FF) + 1.
- R6: A high bit of `int_set` sets the matching raw status bit at the next clock edge. A write to offset 0x28 clears each raw status bit whose data bit is 1. If a set and a clear of the same bit fall in one cycle, the set wins. Raw status reads at offset 0x20.
- R7: Offset 0x24 reads raw status AND mask. `irq_o` is the OR of those bits in the same cycle.
- R8: Offset 0x2C reads the upper base and offset 0x30 reads the lower base.
- R9: Offsets 0xFE0..0xFFC return one byte per word, zero-extended. VARIANT 0 and 1 return 10,11,04,00,0D,F0,05,B1 (hex), and VARIANT 2 returns 11,11,24,00,0D,F0,05,B1, in rising address order.
- R10: A read returns zero at any other offset, at an offset that is not a multiple of 4, and at the write-only offset 0x28. A write to any of these offsets, or to the read-only offsets 0x20, 0x24, 0x2C and 0x30, changes no stored state.
- R11: Offsets 0x200..0x3FC form the palette window. During a write access there, `pal_we` is high, `pal_idx` = paddr[8:2] and `pal_wdata` = pwdata. A read there returns `pal_rdata`. Outside a palette write, `pal_we` is low.
- R12: The cycle after any write access (psel, penable and pwrite all high at an edge), `invalidate_o` is high. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset in the window |
| pwdata | input | DW | Write data |
| prdata | output | DW | Read data, combinational from paddr |
| int_set | input | NIRQ | Event strobes that set raw status |
| irq_o | output | 1 | Interrupt request |
| ctrl_o | output | DW | Control word |
| upbase_o | output | DW | Upper panel base address |
| lpbase_o | output | DW | Lower panel base address |
| cols_o | output | 11 | Active pixels per line |
| rows_o | output | 11 | Active lines per panel |
| invalidate_o | output | 1 | One-cycle pulse after a write |
| pal_we | output | 1 | Palette write strobe |
| pal_idx | output | 7 | Palette word index |
| pal_wdata | output | DW | Palette write data |
| pal_rdata | input | DW | Palette read data |

## Verification
The bench builds three instances on a shared bus, with VARIANT 0, 1 and 2. This lets every variant-dependent address swap and identification byte be compared side by side after the same writes. It uses NIRQ = 4, so all 256 combinations of raw status and mask can be swept, and all 256 combinations of status and clear pattern as well. The timing fields are swept exhaustively: every value of the low byte of timing0 and all 1024 row codes of timing1, with unrelated upper bits set so that any leak into the decoded size shows.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

  localparam int GEOM_W = 11;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_TIM, SEL_UPB, SEL_LPB, SEL_MASK, SEL_CTRL, SEL_RIS,
    SEL_MIS, SEL_ICR, SEL_UPCUR, SEL_LPCUR, SEL_ID, SEL_PAL
  } sel_e;

  function automatic logic [7:0] id_byte(input int variant, input logic [2:0] k);
    logic ext;
    ext = (variant == 2);
    case (k)
      3'd0:    id_byte = ext ? 8'h11 : 8'h10;
      3'd1:    id_byte = 8'h11;
      3'd2:    id_byte = ext ? 8'h24 : 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode
  import lcdc_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic [11:0] paddr,
  output sel_e        sel,
  output logic [1:0]  tim_idx
);
  localparam bit SWAP = (VARIANT != 0);

  always_comb begin
    sel = SEL_NONE;
    if (paddr[1:0] != 2'b00) begin
      sel = SEL_NONE;
    end else if (paddr[11:9] == 3'b001) begin
      sel = SEL_PAL;
    end else if (paddr[11:5] == 7'h7F) begin
      sel = SEL_ID;
    end else if (paddr[11:6] == 6'd0) begin
      case (paddr[5:2])
        4'd0, 4'd1, 4'd2, 4'd3: sel = SEL_TIM;
        4'd4:  sel = SEL_UPB;
        4'd5:  sel = SEL_LPB;
        4'd6:  sel = SWAP ? SEL_CTRL : SEL_MASK;
        4'd7:  sel = SWAP ? SEL_MASK : SEL_CTRL;
        4'd8:  sel = SEL_RIS;
        4'd9:  sel = SEL_MIS;
        4'd10: sel = SEL_ICR;
        4'd11: sel = SEL_UPCUR;
        4'd12: sel = SEL_LPCUR;
        default: sel = SEL_NONE;
      endcase
    end
  end

  assign tim_idx = paddr[3:2];
endmodule

// File: rtl/lcdc_irq.sv
module lcdc_irq #(
  parameter int NIRQ = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_we,
  input  logic            clr_we,
  input  logic [NIRQ-1:0] wbits,
  input  logic [NIRQ-1:0] int_set,
  output logic [NIRQ-1:0] raw_q,
  output logic [NIRQ-1:0] mask_q,
  output logic            irq
);
  logic [NIRQ-1:0] clr_bits;
  assign clr_bits = clr_we ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_bits) | int_set;
      if (mask_we) mask_q <= wbits;
    end
  end

  assign irq = |(raw_q & mask_q);
endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom
  import lcdc_pkg::*;
(
  input  logic [5:0]        ppl_code,
  input  logic [9:0]        lpp_code,
  output logic [GEOM_W-1:0] cols,
  output logic [GEOM_W-1:0] rows
);
  logic [GEOM_W-1:0] ppl_ext;
  assign ppl_ext = {{(GEOM_W-6){1'b0}}, ppl_code};
  assign cols    = (ppl_ext + GEOM_W'(1)) << 4;
  assign rows    = {{(GEOM_W-10){1'b0}}, lpp_code} + GEOM_W'(1);
endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
  import lcdc_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int NIRQ    = 5,
  parameter int DW      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [11:0]       paddr,
  input  logic [DW-1:0]     pwdata,
  output logic [DW-1:0]     prdata,
  input  logic [NIRQ-1:0]   int_set,
  output logic              irq_o,
  output logic [DW-1:0]     ctrl_o,
  output logic [DW-1:0]     upbase_o,
  output logic [DW-1:0]     lpbase_o,
  output logic [GEOM_W-1:0] cols_o,
  output logic [GEOM_W-1:0] rows_o,
  output logic              invalidate_o,
  output logic              pal_we,
  output logic [6:0]        pal_idx,
  output logic [DW-1:0]     pal_wdata,
  input  logic [DW-1:0]     pal_rdata
);
  localparam int NTIM = 4;

  logic          wr_acc;
  sel_e          sel;
  logic [1:0]    tim_idx;
  logic [DW-1:0] tim_q [NTIM];
  logic [DW-1:0] upb_q, lpb_q, ctrl_q;
  logic [NIRQ-1:0] raw_q, mask_q;
  logic          inval_q;

  assign wr_acc = psel & penable & pwrite;

  lcdc_decode #(.VARIANT(VARIANT)) u_dec (
    .paddr   (paddr),
    .sel     (sel),
    .tim_idx (tim_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTIM; i++) tim_q[i] <= '0;
      upb_q   <= '0;
      lpb_q   <= '0;
      ctrl_q  <= '0;
      inval_q <= 1'b0;
    end else begin
      inval_q <= wr_acc;
      if (wr_acc) begin
        for (int i = 0; i < NTIM; i++)
          if (sel == SEL_TIM && tim_idx == 2'(i)) tim_q[i] <= pwdata;
        if (sel == SEL_UPB)  upb_q  <= pwdata;
        if (sel == SEL_LPB)  lpb_q  <= pwdata;
        if (sel == SEL_CTRL) ctrl_q <= pwdata;
      end
    end
  end

  lcdc_irq #(.NIRQ(NIRQ)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_we (wr_acc && sel == SEL_MASK),
    .clr_we  (wr_acc && sel == SEL_ICR),
    .wbits   (pwdata[NIRQ-1:0]),
    .int_set (int_set),
    .raw_q   (raw_q),
    .mask_q  (mask_q),
    .irq     (irq_o)
  );

  lcdc_geom u_geom (
    .ppl_code (tim_q[0][7:2]),
    .lpp_code (tim_q[1][9:0]),
    .cols     (cols_o),
    .rows     (rows_o)
  );

  assign pal_we    = wr_acc && (sel == SEL_PAL);
  assign pal_idx   = paddr[8:2];
  assign pal_wdata = pwdata;

  always_comb begin
    case (sel)
      SEL_TIM:             prdata = tim_q[tim_idx];
      SEL_UPB, SEL_UPCUR:  prdata = upb_q;
      SEL_LPB, SEL_LPCUR:  prdata = lpb_q;
      SEL_CTRL:            prdata = ctrl_q;
      SEL_MASK:            prdata = {{(DW-NIRQ){1'b0}}, mask_q};
      SEL_RIS:             prdata = {{(DW-NIRQ){1'b0}}, raw_q};
      SEL_MIS:             prdata = {{(DW-NIRQ){1'b0}}, raw_q & mask_q};
      SEL_ID:              prdata = {{(DW-8){1'b0}}, id_byte(VARIANT, paddr[4:2])};
      SEL_PAL:             prdata = pal_rdata;
      default:             prdata = '0;
    endcase
  end

  assign ctrl_o       = ctrl_q;
  assign upbase_o     = upb_q;
  assign lpbase_o     = lpb_q;
  assign invalidate_o = inval_q;
endmodule

// File: rtl/lcdc_regs_chk.sv
module lcdc_regs_chk #(
  parameter int NIRQ = 5,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            psel,
  input logic            penable,
  input logic            pwrite,
  input logic [11:0]     paddr,
  input logic [DW-1:0]   pwdata,
  input logic [NIRQ-1:0] int_set,
  input logic            irq_o,
  input logic [10:0]     cols_o,
  input logic [10:0]     rows_o,
  input logic            invalidate_o,
  input logic            pal_we
);
  logic wr;
  assign wr = psel && penable && pwrite;

  p_inval_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> invalidate_o);

  p_inval_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> !invalidate_o);

  p_pal_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we |-> (wr && paddr[11:9] == 3'b001 && paddr[1:0] == 2'b00));

  p_geom_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && paddr[11:3] == 9'd0) |=> ($stable(cols_o) && $stable(rows_o)));

  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == 12'h028 && pwdata[NIRQ-1:0] == {NIRQ{1'b1}} && int_set == '0)
      |=> !irq_o);

  p_cols_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cols_o[3:0] == 4'd0 && cols_o != 11'd0);

  p_rows_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rows_o != 11'd0 && rows_o <= 11'd1024);
endmodule

bind lcdc_regs lcdc_regs_chk #(.NIRQ(NIRQ), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .psel         (psel),
  .penable      (penable),
  .pwrite       (pwrite),
  .paddr        (paddr),
  .pwdata       (pwdata),
  .int_set      (int_set),
  .irq_o        (irq_o),
  .cols_o       (cols_o),
  .rows_o       (rows_o),
  .invalidate_o (invalidate_o),
  .pal_we       (pal_we)
);

// File: tb/lcdc_regs_tb.sv
module lcdc_regs_tb;
  localparam int NI = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [NI-1:0] int_set = '0;

  logic [31:0] prd [3];
  logic irq [3], inval [3], pwe [3];
  logic [31:0] ctrl [3], upb [3], lpb [3], pwd [3], prin [3];
  logic [10:0] cols [3], rows [3];
  logic [6:0] pidx [3];

  for (genvar g = 0; g < 3; g++) begin : g_pal
    assign prin[g] = {16'hC0DE, 9'd0, pidx[g]};
  end

  lcdc_regs #(.VARIANT(0), .NIRQ(NI)) u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prd[0]), .int_set(int_set),
    .irq_o(irq[0]), .ctrl_o(ctrl[0]), .upbase_o(upb[0]), .lpbase_o(lpb[0]),
    .cols_o(cols[0]), .rows_o(rows[0]), .invalidate_o(inval[0]), .pal_we(pwe[0]),
    .pal_idx(pidx[0]), .pal_wdata(pwd[0]), .pal_rdata(prin[0]));

  lcdc_regs #(.VARIANT(1), .NIRQ(NI)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prd[1]), .int_set(int_set),
    .irq_o(irq[1]), .ctrl_o(ctrl[1]), .upbase_o(upb[1]), .lpbase_o(lpb[1]),
    .cols_o(cols[1]), .rows_o(rows[1]), .invalidate_o(inval[1]), .pal_we(pwe[1]),
    .pal_idx(pidx[1]), .pal_wdata(pwd[1]), .pal_rdata(prin[1]));

  lcdc_regs #(.VARIANT(2), .NIRQ(NI)) u_dut_x (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prd[2]), .int_set(int_set),
    .irq_o(irq[2]), .ctrl_o(ctrl[2]), .upbase_o(upb[2]), .lpbase_o(lpb[2]),
    .cols_o(cols[2]), .rows_o(rows[2]), .invalidate_o(inval[2]), .pal_we(pwe[2]),
    .pal_idx(pidx[2]), .pal_wdata(pwd[2]), .pal_rdata(prin[2]));

  int n_chk = 0, n_fail = 0;
  logic [31:0] r0, r1, r2;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk); psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    #1; r0 = prd[0]; r1 = prd[1]; r2 = prd[2];
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic pulse_set(input logic [NI-1:0] v);
    @(negedge clk); int_set = v;
    @(negedge clk); int_set = '0;
  endtask

  function automatic logic [7:0] exp_id(input int v, input int k);
    logic [7:0] t [8];
    t = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (v == 2 && k == 0) return 8'h11;
    if (v == 2 && k == 2) return 8'h24;
    return t[k];
  endfunction

  initial begin
    #(20 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 13; a++) begin
      rd(12'(a * 4));
      chk("R1 reg zero", r0, 32'd0);
    end
    chk("R1 irq", {31'd0, irq[0]}, 32'd0);
    chk("R1 cols", {21'd0, cols[0]}, 32'd16);
    chk("R1 rows", {21'd0, rows[0]}, 32'd1);

    // R2 readback
    wr(12'h000, 32'h1234_56F0); wr(12'h004, 32'hABCD_0123);
    wr(12'h008, 32'h0F0F_1111); wr(12'h00C, 32'h8000_0001);
    wr(12'h010, 32'hC000_1000); wr(12'h014, 32'hC008_0000);
    rd(12'h000); chk("R2 timing0", r0, 32'h1234_56F0);
    rd(12'h004); chk("R2 timing1", r0, 32'hABCD_0123);
    rd(12'h008); chk("R2 timing2", r0, 32'h0F0F_1111);
    rd(12'h00C); chk("R2 timing3", r0, 32'h8000_0001);
    rd(12'h010); chk("R2 upper", r0, 32'hC000_1000);
    rd(12'h014); chk("R2 lower", r0, 32'hC008_0000);
    chk("R2 upbase_o", upb[0], 32'hC000_1000);
    chk("R2 lpbase_o", lpb[0], 32'hC008_0000);

    // R8 current address
    rd(12'h02C); chk("R8 upper cur", r0, 32'hC000_1000);
    rd(12'h030); chk("R8 lower cur", r0, 32'hC008_0000);

    // R3 swap
    wr(12'h018, 32'h0000_0ABC);
    wr(12'h01C, 32'h0000_0003);
    rd(12'h018);
    chk("R3 v0 mask", r0, 32'h0000_000C);
    chk("R3 v1 ctrl", r1, 32'h0000_0ABC);
    chk("R3 v2 ctrl", r2, 32'h0000_0ABC);
    rd(12'h01C);
    chk("R3 v0 ctrl", r0, 32'h0000_0003);
    chk("R3 v1 mask", r1, 32'h0000_0003);
    chk("R3 v2 mask", r2, 32'h0000_0003);
    chk("R2 ctrl_o v0", ctrl[0], 32'h0000_0003);
    chk("R3 ctrl_o v2", ctrl[2], 32'h0000_0ABC);

    // R12 invalidate pulse
    wr(12'h008, 32'h5);
    chk("R12 pulse high", {31'd0, inval[0]}, 32'd1);
    @(negedge clk);
    chk("R12 pulse low", {31'd0, inval[0]}, 32'd0);
    wr(12'h0F0, 32'h5);
    chk("R12 undefined write pulse", {31'd0, inval[0]}, 32'd1);
    rd(12'h000);
    chk("R12 no pulse on read", {31'd0, inval[0]}, 32'd0);

    // R4 cols sweep
    for (int v = 0; v < 256; v++) begin
      wr(12'h000, {24'hA5A5A5, 8'(v)});
      chk("R4 cols", {21'd0, cols[0]}, 32'(((v & 8'hFC) + 4) * 4));
    end
    // R5 rows sweep
    for (int v = 0; v < 1024; v++) begin
      wr(12'h004, {22'h2AAAAA, 10'(v)});
      chk("R5 rows", {21'd0, rows[0]}, 32'(v + 1));
    end

    // R7 raw & mask sweep
    for (int r = 0; r < 16; r++) begin
      for (int m = 0; m < 16; m++) begin
        wr(12'h028, 32'hF);
        pulse_set(4'(r));
        wr(12'h018, 32'(m));
        rd(12'h020); chk("R6 raw set", r0, 32'(r));
        rd(12'h024); chk("R7 masked", r0, 32'(r & m));
        chk("R7 irq", {31'd0, irq[0]}, {31'd0, |4'(r & m)});
      end
    end

    // R6 clear sweep
    for (int r = 0; r < 16; r++) begin
      for (int c = 0; c < 16; c++) begin
        wr(12'h028, 32'hF);
        pulse_set(4'(r));
        wr(12'h028, {28'hFFFFFFF, 4'(c)});
        rd(12'h020); chk("R6 clear", r0, 32'(r & ~c & 4'hF));
      end
    end

    // R6 set wins over clear
    wr(12'h028, 32'hF);
    @(negedge clk); int_set = 4'b0101;
    wr(12'h028, 32'hF);
    int_set = '0;
    rd(12'h020); chk("R6 set wins", r0, 32'h5);

    // R9 ID bytes
    for (int k = 0; k < 8; k++) begin
      rd(12'(12'hFE0 + k * 4));
      chk("R9 id v0", r0, {24'd0, exp_id(0, k)});
      chk("R9 id v1", r1, {24'd0, exp_id(1, k)});
      chk("R9 id v2", r2, {24'd0, exp_id(2, k)});
    end

    // R10 undefined reads and ignored writes
    wr(12'h028, 32'hF); pulse_set(4'b0110);
    wr(12'h018, 32'h3);
    wr(12'h01C, 32'h77);
    foreach (r0[i]) begin end
    for (int i = 0; i < 13; i++) begin
      logic [11:0] a;
      case (i)
        0: a = 12'h034; 1: a = 12'h038; 2: a = 12'h03C; 3: a = 12'h040;
        4: a = 12'h100; 5: a = 12'h1FC; 6: a = 12'h400; 7: a = 12'hFDC;
        8: a = 12'h800; 9: a = 12'h001; 10: a = 12'h013; 11: a = 12'h028;
        default: a = 12'hFE2;
      endcase
      rd(a); chk("R10 read zero", r0, 32'd0);
    end
    wr(12'h034, 32'hFFFF_FFFF); wr(12'h040, 32'hFFFF_FFFF);
    wr(12'h800, 32'hFFFF_FFFF); wr(12'h011, 32'hFFFF_FFFF);
    wr(12'h020, 32'hFFFF_FFFF); wr(12'h024, 32'hFFFF_FFFF);
    wr(12'h02C, 32'hFFFF_FFFF); wr(12'h030, 32'hFFFF_FFFF);
    rd(12'h010); chk("R10 upper kept", r0, 32'hC000_1000);
    rd(12'h014); chk("R10 lower kept", r0, 32'hC008_0000);
    rd(12'h008); chk("R10 timing2 kept", r0, 32'h5);
    rd(12'h018); chk("R10 mask kept", r0, 32'h3);
    rd(12'h01C); chk("R10 ctrl kept", r0, 32'h77);
    rd(12'h020); chk("R10 raw kept", r0, 32'h6);

    // R11 palette pass-through
    for (int k = 0; k < 128; k += 21) begin
      logic [31:0] d;
      d = 32'h1357_0000 | 32'(k);
      @(negedge clk); psel = 1'b1; pwrite = 1'b1; paddr = 12'(12'h200 + k * 4);
      pwdata = d; penable = 1'b0;
      #1; chk("R11 no we in setup", {31'd0, pwe[0]}, 32'd0);
      @(negedge clk); penable = 1'b1;
      #1;
      chk("R11 we", {31'd0, pwe[0]}, 32'd1);
      chk("R11 idx", {25'd0, pidx[0]}, 32'(k));
      chk("R11 wdata", pwd[0], d);
      @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
      rd(12'(12'h200 + k * 4));
      chk("R11 rdata", r0, {16'hC0DE, 9'd0, 7'(k)});
      chk("R11 no we on read", {31'd0, pwe[0]}, 32'd0);
    end
    rd(12'h010); chk("R11 palette write isolated", r0, 32'hC000_1000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule